// File: doc/BRIEF.md
# Prescaled Timer Time Base

This block is the counting core of a general-purpose timer. A programmable prescaler divides the system clock into count ticks. Each tick steps a counter of configurable width against an auto-reload limit. The counter runs in one of three ways: upward, downward, or up-then-down in center-aligned fashion. Each time the count turns over, the block raises a single-cycle update strobe. In one-shot operation it stops itself at that moment.

Software drives the block through a write-only register port with four word addresses: control, prescaler, reload limit and counter. A prescaler value written while the timer runs sits in a shadow register. It is copied into the active divider only at the next update, so the period in progress finishes at its old length. A control write with the update-request bit set restarts the time base at once.

Top module: `tmr_base`

## Requirements
- R1: After reset the counter is 0, the update strobe is low, the direction output is 0 (up), the run output is 0, the reload limit is all ones, and both the active and shadow prescaler values are 0.
- R2: While the run bit (control address 0, bit 0) is 0, the counter and the prescaler phase hold their values. A counter write (R11) or an update request (R10) still takes effect.
- R3: With an active prescaler value P and the run bit set, the counter takes one step every P+1 clock cycles.
- R4: In edge mode with direction 0, each tick increments the counter. When a tick finds the counter at or above the reload limit (address 2), the counter wraps to 0 instead, and `upd_o` is high for the one cycle in which `cnt_o` first shows 0.
- R5: In edge mode with direction 1, each tick decrements the counter. When a tick finds the counter at 0, it reloads the limit instead, and `upd_o` is high for the one cycle in which the reloaded value first appears.
- R6: With the center bit (control bit 3) set, the counter climbs to the limit and then descends to 0, and so on. A tick at the limit while rising moves the counter to limit-1. A tick at 0 while falling moves it to 1. Both turns raise `upd_o`, and `dir_o` shows the direction in which the counter is actually moving (0 rising, 1 falling).
- R7: Control bit 2 sets the direction when the same write selects edge mode. When the write selects center mode, the bit is ignored and `dir_o` keeps its hardware value.
- R8: With the one-shot bit (control bit 1) set, the update that the counter produces on its own clears the run bit. The counter then stays at its wrapped or reloaded value.
- R9: A prescaler write (address 1, low 16 bits) lands in a shadow register. That value becomes the active divider only at the next update, whether the counter produces it or software requests it.
- R10: A control write with bit 4 set restarts the time base, whether or not the timer is running. The counter becomes 0, or the limit when the write selects edge mode with direction 1. The prescaler phase clears, the shadow prescaler becomes active, `upd_o` pulses on the next cycle, and center mode restarts rising.
- R11: A write to address 3 loads the counter directly and takes precedence over a counting step in the same cycle. Such a write raises no update.
- R12: With a reload limit of 0, every tick leaves the counter at 0 and raises `upd_o`, in all three modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 control, 1 prescaler, 2 reload limit, 3 counter |
| wr_data_i | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current counter value |
| upd_o | output | 1 | One-cycle update strobe |
| dir_o | output | 1 | Counting direction, 0 up, 1 down |
| run_o | output | 1 | Run bit, cleared by hardware in one-shot operation |

## Verification
The bench builds the block with the default 16-bit counter and 16-bit prescaler. It programs reload limits of 0 to 5 and divide ratios of 1 to 3, so a short run covers many wraps, reloads and center turns in every mode. Those small values also let it place a prescaler rewrite in the middle of a divided period, start from a counter value above the limit, and trigger a one-shot stop at a known cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_PSC  = 2'd1,
        SEL_LIM  = 2'd2,
        SEL_CNT  = 2'd3
    } reg_sel_e;

    localparam int CTRL_W = 5;

    // Control word layout, bit 0 first: run, one_shot, down, center, restart
    typedef struct packed {
        logic restart;
        logic center;
        logic down;
        logic one_shot;
        logic run;
    } ctrl_t;

    function automatic ctrl_t to_ctrl(input logic [CTRL_W-1:0] raw);
        return ctrl_t'(raw);
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic             nat_evt_i,
    output logic             en_q_o,
    output logic             opm_q_o,
    output logic             center_q_o,
    output logic [CNT_W-1:0] lim_q_o,
    output logic             ctrl_we_o,
    output ctrl_t            ctrl_new_o,
    output logic             restart_o,
    output logic             psc_we_o,
    output logic             cnt_we_o
);

    logic lim_we;

    always_comb begin
        ctrl_new_o = to_ctrl(wr_data_i[CTRL_W-1:0]);
        ctrl_we_o  = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_CTRL);
        psc_we_o   = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_PSC);
        lim_we     = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_LIM);
        cnt_we_o   = wr_en_i && (reg_sel_e'(wr_addr_i) == SEL_CNT);
        restart_o  = ctrl_we_o && ctrl_new_o.restart;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q_o     <= 1'b0;
            opm_q_o    <= 1'b0;
            center_q_o <= 1'b0;
            lim_q_o    <= '1;
        end else begin
            if (nat_evt_i && opm_q_o) begin
                en_q_o <= 1'b0;
            end
            if (ctrl_we_o) begin
                en_q_o     <= ctrl_new_o.run;
                opm_q_o    <= ctrl_new_o.one_shot;
                center_q_o <= ctrl_new_o.center;
            end
            if (lim_we) begin
                lim_q_o <= wr_data_i;
            end
        end
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             psc_we_i,
    input  logic [PSC_W-1:0] psc_wdata_i,
    input  logic             reload_i,
    input  logic             restart_i,
    output logic             tick_o
);

    logic [PSC_W-1:0] shadow_q;
    logic [PSC_W-1:0] active_q;
    logic [PSC_W-1:0] phase_q;

    assign tick_o = en_i && (phase_q == active_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shadow_q <= '0;
            active_q <= '0;
            phase_q  <= '0;
        end else begin
            if (psc_we_i) begin
                shadow_q <= psc_wdata_i;
            end
            if (reload_i) begin
                active_q <= shadow_q;
            end
            if (restart_i) begin
                phase_q <= '0;
            end else if (en_i) begin
                phase_q <= tick_o ? '0 : phase_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             center_i,
    input  logic [CNT_W-1:0] lim_i,
    input  logic             ctrl_we_i,
    input  ctrl_t            ctrl_new_i,
    input  logic             restart_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             upd_o,
    output logic             nat_evt_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic at_top;
    logic at_bottom;
    logic turn;

    always_comb begin
        at_top    = (cnt_o >= lim_i);
        at_bottom = (cnt_o == '0);
        if (center_i && (lim_i == '0)) begin
            turn = 1'b1;
        end else begin
            turn = dir_o ? at_bottom : at_top;
        end
        nat_evt_o = tick_i && turn && !restart_i && !cnt_we_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o <= '0;
            dir_o <= 1'b0;
            upd_o <= 1'b0;
        end else begin
            upd_o <= 1'b0;
            if (ctrl_we_i && !ctrl_new_i.center) begin
                dir_o <= ctrl_new_i.down;
            end
            if (restart_i) begin
                upd_o <= 1'b1;
                cnt_o <= (ctrl_new_i.center || !ctrl_new_i.down) ? '0 : lim_i;
                if (ctrl_new_i.center) begin
                    dir_o <= 1'b0;
                end
            end else if (cnt_we_i) begin
                cnt_o <= cnt_wdata_i;
            end else if (tick_i) begin
                upd_o <= turn;
                if (center_i) begin
                    if (lim_i == '0) begin
                        cnt_o <= '0;
                    end else if (!dir_o) begin
                        if (at_top) begin
                            cnt_o <= cnt_o - ONE;
                            dir_o <= 1'b1;
                        end else begin
                            cnt_o <= cnt_o + ONE;
                        end
                    end else begin
                        if (at_bottom) begin
                            cnt_o <= ONE;
                            dir_o <= 1'b0;
                        end else begin
                            cnt_o <= cnt_o - ONE;
                        end
                    end
                end else if (!dir_o) begin
                    cnt_o <= at_top ? '0 : cnt_o + ONE;
                end else begin
                    cnt_o <= at_bottom ? lim_i : cnt_o - ONE;
                end
            end
        end
    end

endmodule

// File: rtl/tmr_base.sv
module tmr_base
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             upd_o,
    output logic             dir_o,
    output logic             run_o
);

    logic             en_q;
    logic             opm_q;
    logic             center_q;
    logic [CNT_W-1:0] lim_q;
    logic             ctrl_we;
    ctrl_t            ctrl_new;
    logic             restart;
    logic             psc_we;
    logic             cnt_we;
    logic             tick;
    logic             nat_evt;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .nat_evt_i  (nat_evt),
        .en_q_o     (en_q),
        .opm_q_o    (opm_q),
        .center_q_o (center_q),
        .lim_q_o    (lim_q),
        .ctrl_we_o  (ctrl_we),
        .ctrl_new_o (ctrl_new),
        .restart_o  (restart),
        .psc_we_o   (psc_we),
        .cnt_we_o   (cnt_we)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .en_i        (en_q),
        .psc_we_i    (psc_we),
        .psc_wdata_i (wr_data_i[PSC_W-1:0]),
        .reload_i    (nat_evt || restart),
        .restart_i   (restart),
        .tick_o      (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tick_i      (tick),
        .center_i    (center_q),
        .lim_i       (lim_q),
        .ctrl_we_i   (ctrl_we),
        .ctrl_new_i  (ctrl_new),
        .restart_i   (restart),
        .cnt_we_i    (cnt_we),
        .cnt_wdata_i (wr_data_i),
        .cnt_o       (cnt_o),
        .dir_o       (dir_o),
        .upd_o       (upd_o),
        .nat_evt_o   (nat_evt)
    );

    assign run_o = en_q;

endmodule

// File: rtl/tmr_base_chk.sv
module tmr_base_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             wr_en_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic             upd_o,
    input logic             dir_o,
    input logic             run_o,
    input logic             tick,
    input logic             center_q,
    input logic             opm_q,
    input logic [CNT_W-1:0] lim_q
);

    // R2: a stopped timer with no register write keeps its count
    p_freeze_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!run_o && !wr_en_i) |=> $stable(cnt_o));

    // R3: between prescaler ticks the count does not move
    p_tick_rate_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_o && !tick && !wr_en_i) |=> $stable(cnt_o));

    // R4: edge-up tick at or above the limit wraps to zero with an update
    p_up_wrap_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick && !center_q && !dir_o && (cnt_o >= lim_q) && !wr_en_i)
        |=> (cnt_o == '0) && upd_o);

    // R5: edge-down tick at zero reloads the limit with an update
    p_down_reload_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick && !center_q && dir_o && (cnt_o == '0) && !wr_en_i)
        |=> (cnt_o == $past(lim_q)) && upd_o);

    // R6: a counter-made update in center mode flips the direction (limit above 0)
    p_center_flip_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick && center_q && (lim_q != '0) && !wr_en_i
         && (dir_o ? (cnt_o == '0) : (cnt_o >= lim_q)))
        |=> (dir_o != $past(dir_o)) && upd_o);

    // R8: a one-shot timer is stopped after its own update
    p_one_shot_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (opm_q && run_o && tick && !wr_en_i && !center_q
         && (dir_o ? (cnt_o == '0) : (cnt_o >= lim_q)))
        |=> !run_o);

endmodule

bind tmr_base tmr_base_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .wr_en_i  (wr_en_i),
    .cnt_o    (cnt_o),
    .upd_o    (upd_o),
    .dir_o    (dir_o),
    .run_o    (run_o),
    .tick     (tick),
    .center_q (center_q),
    .opm_q    (opm_q),
    .lim_q    (lim_q)
);

// File: tb/tmr_base_test.sv
module tmr_base_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int MASK = 32'h0000_FFFF;

    logic             clk_i = 1'b0;
    logic             rst_i = 1'b1;
    logic             wr_en_i = 1'b0;
    logic [1:0]       wr_addr_i = 2'd0;
    logic [CNT_W-1:0] wr_data_i = '0;
    logic [CNT_W-1:0] cnt_o;
    logic             upd_o;
    logic             dir_o;
    logic             run_o;

    tmr_base #(.CNT_W(CNT_W), .PSC_W(16)) uut (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .cnt_o     (cnt_o),
        .upd_o     (upd_o),
        .dir_o     (dir_o),
        .run_o     (run_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference state
    int m_en, m_opm, m_center, m_lim, m_dir, m_cnt, m_upd, m_sh, m_act, m_ph;

    always @(posedge clk_i) begin
        int sw, cw, pw, lw, nw, tk, up, turn, ev, d;
        int n_en, n_opm, n_center, n_lim, n_dir, n_cnt, n_upd, n_sh, n_act, n_ph;
        if (rst_i) begin
            m_en = 0; m_opm = 0; m_center = 0; m_lim = MASK; m_dir = 0;
            m_cnt = 0; m_upd = 0; m_sh = 0; m_act = 0; m_ph = 0;
        end else begin
            d  = int'(wr_data_i);
            cw = int'(wr_en_i && wr_addr_i == 2'd0);
            pw = int'(wr_en_i && wr_addr_i == 2'd1);
            lw = int'(wr_en_i && wr_addr_i == 2'd2);
            nw = int'(wr_en_i && wr_addr_i == 2'd3);
            sw = (cw != 0 && d[4]) ? 1 : 0;
            tk = (m_en != 0 && m_ph == m_act) ? 1 : 0;
            up = (m_dir == 0) ? 1 : 0;
            if (m_center != 0 && m_lim == 0) turn = 1;
            else if (up != 0) turn = (m_cnt >= m_lim) ? 1 : 0;
            else turn = (m_cnt == 0) ? 1 : 0;
            ev = (tk != 0 && turn != 0 && sw == 0 && nw == 0) ? 1 : 0;
            n_en = m_en; n_opm = m_opm; n_center = m_center; n_lim = m_lim;
            n_dir = m_dir; n_cnt = m_cnt; n_upd = 0; n_sh = m_sh; n_act = m_act; n_ph = m_ph;
            if (cw != 0 && !d[3]) n_dir = d[2];
            if (sw != 0) begin
                n_upd = 1;
                n_cnt = (d[3] || !d[2]) ? 0 : m_lim;
                if (d[3]) n_dir = 0;
            end else if (nw != 0) begin
                n_cnt = d & MASK;
            end else if (tk != 0) begin
                n_upd = turn;
                if (m_center != 0) begin
                    if (m_lim == 0) n_cnt = 0;
                    else if (up != 0) begin
                        if (m_cnt >= m_lim) begin n_cnt = m_cnt - 1; n_dir = 1; end
                        else n_cnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin n_cnt = 1; n_dir = 0; end
                        else n_cnt = m_cnt - 1;
                    end
                end else if (up != 0) n_cnt = (m_cnt >= m_lim) ? 0 : m_cnt + 1;
                else n_cnt = (m_cnt == 0) ? m_lim : m_cnt - 1;
            end
            if (pw != 0) n_sh = d & MASK;
            if (ev != 0 || sw != 0) n_act = m_sh;
            if (sw != 0) n_ph = 0;
            else if (m_en != 0) n_ph = (tk != 0) ? 0 : m_ph + 1;
            if (ev != 0 && m_opm != 0) n_en = 0;
            if (cw != 0) begin n_en = d[0]; n_opm = d[1]; n_center = d[3]; end
            if (lw != 0) n_lim = d & MASK;
            m_en = n_en; m_opm = n_opm; m_center = n_center; m_lim = n_lim; m_dir = n_dir;
            m_cnt = n_cnt; m_upd = n_upd; m_sh = n_sh; m_act = n_act; m_ph = n_ph;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference, away from the active edge
    always @(negedge clk_i) begin
        if (!rst_i && !done) begin
            check({cur_req, " cnt"}, int'(cnt_o), m_cnt);
            check({cur_req, " upd"}, int'(upd_o), m_upd);
            check({cur_req, " dir"}, int'(dir_o), m_dir);
            check({cur_req, " run"}, int'(run_o), m_en);
        end
    end

    task automatic wr(input int addr, input int data);
        @(negedge clk_i);
        wr_en_i   = 1'b1;
        wr_addr_i = addr[1:0];
        wr_data_i = data[CNT_W-1:0];
        @(negedge clk_i);
        wr_en_i   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_i = 1'b0;
        @(negedge clk_i);
        // R1 reset state
        check("R1 cnt", int'(cnt_o), 0);
        check("R1 upd", int'(upd_o), 0);
        check("R1 dir", int'(dir_o), 0);
        check("R1 run", int'(run_o), 0);

        // R4 edge up, divide by 1
        cur_req = "R4";
        wr(2, 4);
        wr(0, 5'b00001);
        idle(20);

        // R10 restart loading shadow prescaler of 2, R3 divide by 3
        cur_req = "R10";
        wr(1, 2);
        wr(0, 5'b10001);
        check("R10 cnt after restart", int'(cnt_o), 0);
        check("R10 upd after restart", int'(upd_o), 1);
        cur_req = "R3";
        idle(30);

        // R9 shadow prescaler rewritten mid period
        cur_req = "R9";
        idle(1);
        wr(1, 0);
        idle(25);

        // R5 edge down via restart, R7 direction bit
        cur_req = "R5";
        wr(0, 5'b10101);
        check("R5 cnt reloaded to limit", int'(cnt_o), 4);
        check("R7 dir set down", int'(dir_o), 1);
        idle(20);

        // R6 center mode, R7 direction bit ignored in center writes
        cur_req = "R6";
        wr(2, 3);
        wr(0, 5'b11101);
        check("R7 dir ignored in center", int'(dir_o), 0);
        idle(30);
        cur_req = "R7";
        wr(0, 5'b01101);
        idle(12);

        // R2 freeze, R11 counter write while stopped
        cur_req = "R2";
        wr(0, 5'b00000);
        idle(10);
        cur_req = "R11";
        wr(3, 7);
        check("R11 cnt loaded while stopped", int'(cnt_o), 7);
        cur_req = "R2";
        idle(5);
        check("R2 cnt frozen", int'(cnt_o), 7);

        // R4 counter above limit wraps to zero
        cur_req = "R4";
        wr(0, 5'b00001);
        idle(10);

        // R11 counter write while running
        cur_req = "R11";
        wr(2, 5);
        wr(3, 2);
        idle(10);

        // R8 one-shot stop
        cur_req = "R8";
        wr(0, 5'b00000);
        wr(3, 0);
        wr(0, 5'b00011);
        idle(20);
        check("R8 run cleared", int'(run_o), 0);
        check("R8 cnt held at wrap", int'(cnt_o), 0);
        idle(5);

        // R12 zero limit in all modes
        cur_req = "R12";
        wr(2, 0);
        wr(0, 5'b10001);
        idle(6);
        wr(0, 5'b10101);
        idle(6);
        wr(0, 5'b11001);
        idle(6);
        check("R12 cnt stays zero", int'(cnt_o), 0);
        check("R12 upd every tick", int'(upd_o), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule